// File: doc/BRIEF.md
# Camera FIFO readout pixel assembler

This block runs the read side of an external byte-wide frame buffer FIFO that sits behind an image sensor. It drives the FIFO's active-low read-pointer reset, its active-low output enable and its read clock. It samples the 8-bit data bus and joins each pair of bytes into one 16-bit RGB565 pixel. The pixels leave on a valid/ready stream.

A one-cycle start command rewinds the FIFO read pointer and then reads a whole frame. The frame size is fixed when the frame starts: full size (default 320x240) or reduced size (default 160x120). After the last pixel has been taken, the block pulses a frame-complete strobe and parks until a stop command arrives. The stop disables the FIFO outputs, clocks one dummy byte and leaves the read clock high. The read-clock timing is set by a parameter: each high or low level lasts a given number of system clocks, never fewer than two.

Top module: `camFifoReader`

## Requirements
- R1: After reset the FIFO pins are at their idle levels: fifoRdRstN=1, fifoOeN=1 and fifoRclk=1. pixValid and frameDone are 0.
- R2: On a start in idle, fifoRdRstN and fifoOeN go low together. While fifoRdRstN is low, fifoRclk goes low and then high exactly once. fifoRdRstN is then released high while fifoRclk is still high.
- R3: Every fifoRclk level lasts at least PHASE_CYC system clocks. The low level between the two bytes of a pixel and the high level of the second byte each last exactly PHASE_CYC clocks.
- R4: A byte is sampled in the last system clock of a fifoRclk high level. The first byte read after the rewind is the byte the FIFO presented at the rewind edge. Of each pixel, the first byte read forms pixData[7:0] and the second forms pixData[15:0] bits 15:8.
- R5: A frame is FULL_W*FULL_H pixels when halfMode=0 at the start cycle, and HALF_W*HALF_H pixels when halfMode=1. A change of halfMode after the start cycle has no effect on the current frame.
- R6: While pixValid=1 and pixReady=0 (and no stop), pixValid stays 1, pixData stays unchanged and fifoRclk has no rising edge.
- R7: frameDone is high for exactly one cycle, in the cycle after the last pixel of the frame is accepted. After that, fifoRclk has no rising edge and pixValid stays 0 until a stop arrives.
- R8: A stop raises fifoOeN while fifoRclk is high. It then makes exactly one falling fifoRclk edge with fifoOeN high, and ends in idle with fifoRclk high. pixValid is 0 whenever fifoOeN is high.
- R9: A stop issued while a pixel is pending and not accepted drops that pixel. A stop issued during the rewind or a byte read is held until the current pixel's second byte has been read; that pixel is never offered. No frameDone follows a stop of either kind.
- R10: A start while a frame is in progress is ignored: no second rewind, and the pixel sequence is unchanged. A stop in idle is ignored: no fifoRclk edge, and fifoOeN stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCmd | input | 1 | One-cycle command that rewinds the FIFO and begins a frame |
| stopCmd | input | 1 | One-cycle command that ends the frame |
| halfMode | input | 1 | Frame size select sampled at start: 1 = reduced, 0 = full |
| fifoData | input | BYTE_W | FIFO read data bus |
| fifoRdRstN | output | 1 | FIFO read-pointer reset, active low |
| fifoOeN | output | 1 | FIFO output enable, active low |
| fifoRclk | output | 1 | FIFO read clock |
| pixData | output | 2*BYTE_W | Assembled pixel, first byte in the low half |
| pixValid | output | 1 | Pixel available |
| pixReady | input | 1 | Downstream accepts the pixel |
| frameDone | output | 1 | One-cycle pulse after the last pixel of a frame is accepted |

## Verification
The bench builds the block with a 4x3 full frame, a 2x2 reduced frame and PHASE_CYC=3. With these sizes, whole frames in both modes, the last-pixel boundary, the frame-complete pulse and the stop sequence all fit in a few hundred cycles. The mode-change-after-start case can be checked by the pixel count, because the two sizes differ. A phase of 3 instead of the minimum 2 means that a phase cut short or stretched by one clock shows up in the measured run lengths. The FIFO model presents a new byte on each rising read-clock edge, and the bench computes every expected pixel from the seed of that frame.

// File: rtl/camFifoPkg.sv
package camFifoPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_ARM,
    ST_RST_LO,
    ST_RST_HI,
    ST_B0_HI,
    ST_B0_LO,
    ST_B1_HI,
    ST_B1_LO,
    ST_PIX,
    ST_END,
    ST_STOP_HI,
    ST_STOP_LO
  } rdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMode;
    logic clearCount;
    logic bumpCount;
    logic grabLow;
    logic grabHigh;
  } dpStrobe_t;

  typedef struct packed {
    logic rdRstN;
    logic oeN;
    logic rclk;
  } fifoPins_t;

endpackage

// File: rtl/camFifoDatapath.sv
module camFifoDatapath
  import camFifoPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FULL_W = 320,
  parameter int FULL_H = 240,
  parameter int HALF_W = 160,
  parameter int HALF_H = 120
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                halfMode,
  input  logic [BYTE_W-1:0]   fifoData,
  output logic [2*BYTE_W-1:0] pixData,
  output logic                isLastPix
);

  localparam int FULL_PIX = FULL_W * FULL_H;
  localparam int HALF_PIX = HALF_W * HALF_H;
  localparam int MAX_PIX  = (FULL_PIX > HALF_PIX) ? FULL_PIX : HALF_PIX;
  localparam int CNT_W    = $clog2(MAX_PIX + 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_PIX - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_PIX - 1);

  logic                halfQ;
  logic [CNT_W-1:0]    pixCnt;
  logic [BYTE_W-1:0]   lowByte;
  logic [2*BYTE_W-1:0] pixQ;

  // frame size is frozen at the start command
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfQ <= 1'b0;
    end else if (strobe.loadMode) begin
      halfQ <= halfMode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt <= '0;
    end else if (strobe.clearCount) begin
      pixCnt <= '0;
    end else if (strobe.bumpCount) begin
      pixCnt <= pixCnt + 1'b1;
    end
  end

  // first byte waits in lowByte; the second completes the pixel
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowByte <= '0;
      pixQ    <= '0;
    end else begin
      if (strobe.grabLow)  lowByte <= fifoData;
      if (strobe.grabHigh) pixQ    <= {fifoData, lowByte};
    end
  end

  assign pixData   = pixQ;
  assign isLastPix = (pixCnt == (halfQ ? HALF_LAST : FULL_LAST));

endmodule

// File: rtl/camFifoCtrl.sv
module camFifoCtrl
  import camFifoPkg::*;
#(
  parameter int PHASE_CYC = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startCmd,
  input  logic      stopCmd,
  input  logic      pixReady,
  input  logic      isLastPix,
  output dpStrobe_t strobe,
  output fifoPins_t pins,
  output logic      pixValid,
  output logic      frameDone
);

  localparam int PH   = (PHASE_CYC < 2) ? 2 : PHASE_CYC;
  localparam int PH_W = $clog2(PH + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH - 1);

  rdState_e        state, stateD;
  logic [PH_W-1:0] phaseCnt;
  logic            stopPend;
  logic            timed, phaseEnd, accept;

  function automatic fifoPins_t pinsFor(rdState_e s);
    fifoPins_t p;
    p.rdRstN = !(s inside {ST_RST_ARM, ST_RST_LO, ST_RST_HI});
    p.oeN    = (s inside {ST_IDLE, ST_STOP_HI, ST_STOP_LO});
    p.rclk   = !(s inside {ST_RST_LO, ST_B0_LO, ST_B1_LO, ST_PIX, ST_END, ST_STOP_LO});
    return p;
  endfunction

  assign timed    = !(state inside {ST_IDLE, ST_PIX, ST_END});
  assign phaseEnd = timed && (phaseCnt == PH_LAST);
  assign accept   = (state == ST_PIX) && pixReady;

  always_comb begin
    stateD = state;
    unique case (state)
      ST_IDLE:    if (startCmd) stateD = ST_RST_ARM;
      ST_RST_ARM: if (phaseEnd) stateD = ST_RST_LO;
      ST_RST_LO:  if (phaseEnd) stateD = ST_RST_HI;
      ST_RST_HI:  if (phaseEnd) stateD = ST_B0_HI;
      ST_B0_HI:   if (phaseEnd) stateD = ST_B0_LO;
      ST_B0_LO:   if (phaseEnd) stateD = ST_B1_HI;
      ST_B1_HI:   if (phaseEnd) stateD = ST_B1_LO;
      ST_B1_LO:   if (phaseEnd) stateD = (stopPend || stopCmd) ? ST_STOP_HI : ST_PIX;
      ST_PIX: begin
        if (accept) begin
          if (stopCmd)        stateD = ST_STOP_HI;
          else if (isLastPix) stateD = ST_END;
          else                stateD = ST_B0_HI;
        end else if (stopCmd) begin
          stateD = ST_STOP_HI;
        end
      end
      ST_END:     if (stopCmd)  stateD = ST_STOP_HI;
      ST_STOP_HI: if (phaseEnd) stateD = ST_STOP_LO;
      ST_STOP_LO: if (phaseEnd) stateD = ST_IDLE;
      default:                  stateD = ST_IDLE;
    endcase
  end

  // pins follow the next state so they leave flops, not decode logic
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pins  <= '{rdRstN: 1'b1, oeN: 1'b1, rclk: 1'b1};
    end else begin
      state <= stateD;
      pins  <= pinsFor(stateD);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (stateD != state) begin
      phaseCnt <= '0;
    end else if (timed && (phaseCnt != PH_LAST)) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopPend <= 1'b0;
    end else if (state inside {ST_IDLE, ST_STOP_HI, ST_STOP_LO}) begin
      stopPend <= 1'b0;
    end else if (stopCmd) begin
      stopPend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) frameDone <= 1'b0;
    else       frameDone <= accept && isLastPix;
  end

  assign pixValid          = (state == ST_PIX);
  assign strobe.loadMode   = (state == ST_IDLE) && startCmd;
  assign strobe.clearCount = (state == ST_IDLE) && startCmd;
  assign strobe.bumpCount  = accept;
  assign strobe.grabLow    = (state == ST_B0_HI) && phaseEnd;
  assign strobe.grabHigh   = (state == ST_B1_HI) && phaseEnd;

endmodule

// File: rtl/camFifoReader.sv
module camFifoReader
  import camFifoPkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int FULL_W    = 320,
  parameter int FULL_H    = 240,
  parameter int HALF_W    = 160,
  parameter int HALF_H    = 120,
  parameter int PHASE_CYC = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startCmd,
  input  logic                stopCmd,
  input  logic                halfMode,
  input  logic [BYTE_W-1:0]   fifoData,
  output logic                fifoRdRstN,
  output logic                fifoOeN,
  output logic                fifoRclk,
  output logic [2*BYTE_W-1:0] pixData,
  output logic                pixValid,
  input  logic                pixReady,
  output logic                frameDone
);

  dpStrobe_t strobe;
  fifoPins_t pins;
  logic      isLastPix;

  camFifoCtrl #(
    .PHASE_CYC(PHASE_CYC)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startCmd  (startCmd),
    .stopCmd   (stopCmd),
    .pixReady  (pixReady),
    .isLastPix (isLastPix),
    .strobe    (strobe),
    .pins      (pins),
    .pixValid  (pixValid),
    .frameDone (frameDone)
  );

  camFifoDatapath #(
    .BYTE_W (BYTE_W),
    .FULL_W (FULL_W),
    .FULL_H (FULL_H),
    .HALF_W (HALF_W),
    .HALF_H (HALF_H)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .halfMode  (halfMode),
    .fifoData  (fifoData),
    .pixData   (pixData),
    .isLastPix (isLastPix)
  );

  assign fifoRdRstN = pins.rdRstN;
  assign fifoOeN    = pins.oeN;
  assign fifoRclk   = pins.rclk;

endmodule

// File: rtl/camFifoReaderChk.sv
module camFifoReaderChk #(
  parameter int PHASE_CYC = 2,
  parameter int PIX_W     = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             stopCmd,
  input logic             fifoRdRstN,
  input logic             fifoOeN,
  input logic             fifoRclk,
  input logic             pixValid,
  input logic             pixReady,
  input logic [PIX_W-1:0] pixData,
  input logic             frameDone
);

  localparam int PH   = (PHASE_CYC < 2) ? 2 : PHASE_CYC;
  localparam int RW   = $clog2(PH + 2);
  localparam logic [RW-1:0] RUN_SAT = RW'(PH + 1);
  localparam logic [RW-1:0] RUN_MIN = RW'(PH);

  logic          rclkPrev;
  logic [RW-1:0] runCnt;

  // runCnt holds the length of the level that has just ended
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rclkPrev <= 1'b1;
      runCnt   <= RUN_SAT;
    end else begin
      rclkPrev <= fifoRclk;
      if (fifoRclk != rclkPrev)  runCnt <= RW'(1);
      else if (runCnt != RUN_SAT) runCnt <= runCnt + 1'b1;
    end
  end

  assert_high_phase_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rclkPrev && !fifoRclk) |-> (runCnt >= RUN_MIN));

  assert_low_phase_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!rclkPrev && fifoRclk) |-> (runCnt >= RUN_MIN));

  assert_rewind_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
    !fifoRdRstN |-> !fifoOeN);

  assert_rewind_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoRdRstN) |-> fifoRclk);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady && !stopCmd) |=> (pixValid && $stable(pixData) && !fifoRclk));

  assert_done_after_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(pixValid && pixReady));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  assert_stop_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoOeN) |-> (fifoRclk && !pixValid));

  assert_oe_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    fifoOeN |-> !pixValid);

endmodule

bind camFifoReader camFifoReaderChk #(
  .PHASE_CYC (PHASE_CYC),
  .PIX_W     (2*BYTE_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .stopCmd    (stopCmd),
  .fifoRdRstN (fifoRdRstN),
  .fifoOeN    (fifoOeN),
  .fifoRclk   (fifoRclk),
  .pixValid   (pixValid),
  .pixReady   (pixReady),
  .pixData    (pixData),
  .frameDone  (frameDone)
);

// File: tb/camFifoReader_test.sv
`timescale 1ns/1ps
module camFifoReader_test;

  localparam int FW = 4, FH = 3, HW = 2, HH = 2, PH = 3;
  localparam int FULL_N = FW * FH;
  localparam int HALF_N = HW * HH;

  logic clk = 1'b0, rstN = 1'b0;
  logic startCmd = 1'b0, stopCmd = 1'b0, halfMode = 1'b0, pixReady = 1'b0;
  logic [7:0]  fifoData;
  logic        fifoRdRstN, fifoOeN, fifoRclk, pixValid, frameDone;
  logic [15:0] pixData;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  camFifoReader #(
    .BYTE_W(8), .FULL_W(FW), .FULL_H(FH), .HALF_W(HW), .HALF_H(HH), .PHASE_CYC(PH)
  ) uut (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .stopCmd(stopCmd), .halfMode(halfMode),
    .fifoData(fifoData), .fifoRdRstN(fifoRdRstN), .fifoOeN(fifoOeN), .fifoRclk(fifoRclk),
    .pixData(pixData), .pixValid(pixValid), .pixReady(pixReady), .frameDone(frameDone)
  );

  // FIFO model: the rewind edge shows byte 0, every later rising edge the next byte
  int         seed = 0;
  int         rdPtr = 0;
  logic [7:0] busQ = 8'h00;

  function automatic logic [7:0] byteAt(int s, int i);
    return 8'((i * 29 + s * 71 + 3) ^ (i >> 2));
  endfunction

  always @(posedge fifoRclk) begin
    if (!fifoRdRstN) begin
      busQ  <= byteAt(seed, 0);
      rdPtr <= 1;
    end else begin
      busQ  <= byteAt(seed, rdPtr);
      rdPtr <= rdPtr + 1;
    end
  end
  assign fifoData = fifoOeN ? 8'hEE : busQ;

  // pin monitors
  int allRises = 0, rstRises = 0, rstRisesOeHigh = 0, oeHighFalls = 0;
  always @(posedge fifoRclk) begin
    allRises++;
    if (!fifoRdRstN) begin
      rstRises++;
      if (fifoOeN) rstRisesOeHigh++;
    end
  end
  always @(negedge fifoRclk) if (fifoOeN) oeHighFalls++;

  // run-length monitor and pixel collector, sampled mid-cycle
  int   cyc = 0, runLen = 0, minHigh = 1000, minLow = 1000;
  logic lvlPrev = 1'b1;
  logic [15:0] got [32];
  int   nGot = 0, nDone = 0, lastAccCyc = -10, doneCyc = -10;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (fifoRclk == lvlPrev) runLen++;
      else begin
        if (lvlPrev) minHigh = (runLen < minHigh) ? runLen : minHigh;
        else         minLow  = (runLen < minLow)  ? runLen : minLow;
        runLen = 1;
      end
      lvlPrev = fifoRclk;
      if (pixValid && pixReady) begin
        if (nGot < 32) got[nGot] = pixData;
        nGot++;
        lastAccCyc = cyc;
      end
      if (frameDone) begin
        nDone++;
        doneCyc = cyc;
      end
    end
  end

  // ready driver: 0 = always, 1 = patterned, 2 = never
  int readyMode = 0;
  initial begin
    int pat = 0;
    forever begin
      @(posedge clk);
      #1;
      pixReady = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? ((pat % 3) != 1) : 1'b0;
      pat++;
    end
  end

  task automatic checkEq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic pulseStart();
    @(posedge clk); #1 startCmd = 1'b1;
    @(posedge clk); #1 startCmd = 1'b0;
  endtask

  task automatic pulseStop();
    @(posedge clk); #1 stopCmd = 1'b1;
    @(posedge clk); #1 stopCmd = 1'b0;
  endtask

  task automatic waitStopDone(int f0);
    int k = 0;
    while ((oeHighFalls == f0 || !fifoRclk) && k < 500) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
  endtask

  task automatic clearTallies();
    nGot = 0; nDone = 0; minHigh = 1000; minLow = 1000;
  endtask

  task automatic checkReset();
    @(negedge clk);
    checkEq("R1", "fifoRdRstN idle", fifoRdRstN, 1);
    checkEq("R1", "fifoOeN idle", fifoOeN, 1);
    checkEq("R1", "fifoRclk idle", fifoRclk, 1);
    checkEq("R1", "pixValid idle", pixValid, 0);
    checkEq("R1", "frameDone idle", frameDone, 0);
  endtask

  task automatic runFrame(bit half, int s, int rMode, bit poke);
    int r0, n, bad, k, f0, a0;
    seed = s; readyMode = rMode; halfMode = half;
    clearTallies();
    r0 = rstRises; a0 = rstRisesOeHigh;
    pulseStart();
    halfMode = !half;               // R5: ignored after the start cycle
    if (poke) begin
      repeat (30) @(negedge clk);
      pulseStart();                 // R10: start while busy
    end
    k = 0;
    while (nDone == 0 && k < 5000) begin @(negedge clk); k++; end
    n = half ? HALF_N : FULL_N;
    checkEq("R2", "rewind edges", rstRises - r0, 1);
    checkEq("R2", "rewind edges with outputs off", rstRisesOeHigh - a0, 0);
    checkEq("R5", "pixels in frame", nGot, n);
    bad = 0;
    for (int i = 0; i < n && i < 32; i++) begin
      if (got[i] !== {byteAt(s, 2*i+1), byteAt(s, 2*i)}) begin
        if (bad == 0)
          checkEq("R4", $sformatf("pixel %0d", i), got[i], {byteAt(s, 2*i+1), byteAt(s, 2*i)});
        bad++;
      end
    end
    checkEq("R4", "pixel mismatches", bad, 0);
    checkEq("R7", "frameDone one cycle after last accept", doneCyc - lastAccCyc, 1);
    r0 = allRises;
    repeat (3*PH + 6) @(negedge clk);
    checkEq("R7", "read clock rises after frame end", allRises - r0, 0);
    checkEq("R7", "frameDone pulse count", nDone, 1);
    checkEq("R7", "pixValid after frame end", pixValid, 0);
    f0 = oeHighFalls; r0 = allRises;
    pulseStop();
    waitStopDone(f0);
    repeat (5) @(negedge clk);
    checkEq("R8", "dummy read falls", oeHighFalls - f0, 1);
    checkEq("R8", "read clock rises in stop", allRises - r0, 2);
    checkEq("R8", "fifoRclk after stop", fifoRclk, 1);
    checkEq("R8", "fifoOeN after stop", fifoOeN, 1);
    checkEq("R8", "fifoRdRstN after stop", fifoRdRstN, 1);
    checkEq("R3", "shortest high level", minHigh, PH);
    checkEq("R3", "shortest low level", minLow, PH);
  endtask

  task automatic holdTest();
    int k, r0, f0;
    logic [15:0] d0;
    seed = 5; readyMode = 2; halfMode = 1'b0;
    clearTallies();
    pulseStart();
    k = 0;
    while (!pixValid && k < 500) begin @(negedge clk); k++; end
    d0 = pixData; r0 = allRises;
    repeat (20) @(negedge clk);
    checkEq("R6", "pixValid held", pixValid, 1);
    checkEq("R6", "pixData held", pixData, d0);
    checkEq("R6", "read clock rises while stalled", allRises - r0, 0);
    checkEq("R4", "first pixel", d0, {byteAt(5, 1), byteAt(5, 0)});
    readyMode = 0;
    k = 0;
    while (nDone == 0 && k < 5000) begin @(negedge clk); k++; end
    checkEq("R6", "pixels after stall", nGot, FULL_N);
    f0 = oeHighFalls;
    pulseStop();
    waitStopDone(f0);
  endtask

  task automatic midStopTest();
    int k, f0;
    seed = 9; readyMode = 2; halfMode = 1'b0;
    clearTallies();
    pulseStart();
    k = 0;
    while (!pixValid && k < 500) begin @(negedge clk); k++; end
    f0 = oeHighFalls;
    pulseStop();
    @(negedge clk);
    checkEq("R9", "pending pixel dropped", pixValid, 0);
    waitStopDone(f0);
    readyMode = 0;
    repeat (10) @(negedge clk);
    checkEq("R9", "accepted after pending stop", nGot, 0);
    checkEq("R9", "frameDone after pending stop", nDone, 0);
    checkEq("R8", "dummy read falls on early stop", oeHighFalls - f0, 1);
    // stop during the rewind sequence
    clearTallies();
    f0 = oeHighFalls;
    pulseStart();
    @(negedge clk);
    pulseStop();
    waitStopDone(f0);
    repeat (10) @(negedge clk);
    checkEq("R9", "pixels after stop in rewind", nGot, 0);
    checkEq("R9", "frameDone after stop in rewind", nDone, 0);
    checkEq("R9", "idle oe after stop in rewind", fifoOeN, 1);
  endtask

  task automatic idleStopTest();
    int r0, f0;
    r0 = allRises; f0 = oeHighFalls;
    pulseStop();
    repeat (12) @(negedge clk);
    checkEq("R10", "read clock rises on idle stop", allRises - r0, 0);
    checkEq("R10", "falls on idle stop", oeHighFalls - f0, 0);
    checkEq("R10", "fifoOeN on idle stop", fifoOeN, 1);
    checkEq("R10", "fifoRclk on idle stop", fifoRclk, 1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishSim();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    checkReset();
    runFrame(1'b0, 1, 0, 1'b0);   // full frame, ready always
    runFrame(1'b1, 2, 1, 1'b0);   // reduced frame, patterned ready
    runFrame(1'b0, 3, 1, 1'b1);   // full frame with a start while busy
    holdTest();
    midStopTest();
    idleStopTest();
    runFrame(1'b1, 4, 0, 1'b0);   // clean frame after early stops
    finishSim();
  end

endmodule